// File: doc/BRIEF.md
# Attribute-Typed Configuration Register Bank

This block is a small bank of configuration registers in which every bit has its own access class. The class sets how the bit answers software reads and writes, and how it behaves under the two reset kinds. The bank has a plain register port: an address, write data, byte strobes, a write enable, a read enable, and registered read data. It also has two active-low synchronous resets, one for hot reset and one for fundamental reset. An auxiliary-power flag and a per-bit hardware event input complete the interface.

The layout is set by parameters. Each register has one-hot class masks (plain read-write, lockable, sticky read-only, sticky read-write, sticky write-1-to-clear, write qualifier), a default-value vector and a survive-fundamental-reset mask. Any bit that is in none of the class masks is hardwired to zero. One plain read-write bit, chosen by parameters, is the unlock control for all lockable bits. Read data appears one clock after the cycle in which the read enable is sampled.

Top module: `cfg_attr_regbank`

## Requirements
- R1: A lockable bit always reads back its value. A write changes it only while the unlock bit (register 0, bit 0) holds 1; otherwise the write is dropped.
- R2: Lockable bits keep their value through a hot reset and return to their default on a fundamental reset.
- R3: Software writes never change sticky read-only bits. A hardware event pulse sets such a bit, and a hot reset leaves it unchanged.
- R4: Sticky read-write bits take any written value and are not changed by a hot reset.
- R5: For a sticky status bit, writing 1 clears it and writing 0 has no effect. A hardware event pulse sets it, and a hot reset leaves it unchanged.
- R6: If a hardware event and a software clear reach the same status bit in the same cycle, the bit ends up set.
- R7: During a fundamental reset with auxiliary power present, sticky bits marked to survive keep their value and all other bits load their defaults. Without auxiliary power, every bit loads its default.
- R8: Write-qualifier bits read as 0. In a register that has a qualifier, a write changes no bit unless a qualifier bit is written as 1 in an enabled byte.
- R9: Hardwired-zero bits read as 0, and writes to them are ignored.
- R10: Plain read-write bits (including the unlock bit) return to their default on a hot reset.
- R11: A write changes only the bytes whose strobe is 1; byte n covers bits 8n+7 to 8n.
- R12: Read data is registered. It updates one cycle after a sampled read enable and holds while the read enable is low. A read of an address at or above the register count returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| fund_rst_n | input | 1 | Fundamental reset, active low, synchronous |
| hot_rst_n | input | 1 | Hot reset, active low, synchronous |
| aux_pwr | input | 1 | Auxiliary power present |
| addr | input | ADDR_W | Register index |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Byte write strobes |
| we | input | 1 | Write enable |
| re | input | 1 | Read enable |
| rdata | output | DATA_W | Registered read data |
| hw_set | input | NUM_REGS*DATA_W | Per-bit hardware event set pulses |

## Verification
The bench uses the default parameters: four 16-bit registers behind a 3-bit address, which leaves four unmapped addresses to read. The default layout has at least one bit of every class. Register 2 mixes sticky read-only and sticky read-write bytes with survive masks on half of each byte. Register 3 puts status bits, qualified read-write bits and the qualifier bit in one word. With this layout, the same-cycle set/clear collision, writes blocked by the qualifier, partial survival under auxiliary power, and strobe masking on a lockable register can all be reached through the port.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;

    localparam int unsigned BYTE_W = 8;

    function automatic logic [BYTE_W-1:0] lane_mask(input logic strobe);
        return {BYTE_W{strobe}};
    endfunction

endpackage

// File: rtl/cfg_wr_decode.sv
module cfg_wr_decode #(
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned ADDR_W   = 3
) (
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic                        we_i,
    input  logic [DATA_W/8-1:0]         wstrb_i,
    output logic [NUM_REGS-1:0]         wr_sel_o,
    output logic [DATA_W-1:0]           bmask_o
);
    import cfg_regbank_pkg::*;

    localparam int unsigned LANES = DATA_W / BYTE_W;

    always_comb begin
        for (int r = 0; r < NUM_REGS; r++) begin
            wr_sel_o[r] = we_i && (addr_i == ADDR_W'(r));
        end
    end

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign bmask_o[b*BYTE_W +: BYTE_W] = lane_mask(wstrb_i[b]);
    end

endmodule

// File: rtl/cfg_reg_slice.sv
module cfg_reg_slice #(
    parameter int unsigned W = 16,
    parameter logic [W-1:0] RW_M   = '0,
    parameter logic [W-1:0] RWL_M  = '0,
    parameter logic [W-1:0] ROS_M  = '0,
    parameter logic [W-1:0] RWS_M  = '0,
    parameter logic [W-1:0] W1C_M  = '0,
    parameter logic [W-1:0] WT_M   = '0,
    parameter logic [W-1:0] FRS_M  = '0,
    parameter logic [W-1:0] DEF_M  = '0
) (
    input  logic         clk,
    input  logic         fund_rst_n,
    input  logic         hot_rst_n,
    input  logic         aux_pwr,
    input  logic         wr_en_i,
    input  logic [W-1:0] bmask_i,
    input  logic [W-1:0] wdata_i,
    input  logic         unlock_i,
    input  logic [W-1:0] hw_set_i,
    output logic [W-1:0] val_o
);
    localparam logic [W-1:0] STK_M  = ROS_M | RWS_M | W1C_M;
    localparam logic [W-1:0] LIVE_M = RW_M | RWL_M | STK_M;
    localparam logic [W-1:0] SURV_M = FRS_M & STK_M;
    localparam logic [W-1:0] FREE_M = RW_M | RWS_M;
    localparam bit           HAS_WT = (WT_M != '0);

    typedef struct packed {
        logic [W-1:0] val;
    } slice_t;

    slice_t st_d, st_q;
    logic         qual_ok;
    logic [W-1:0] wmask;
    logic [W-1:0] lmask;
    logic [W-1:0] nxt;
    logic [W-1:0] keep;

    always_comb begin
        st_d    = st_q;
        qual_ok = !HAS_WT || ((wdata_i & bmask_i & WT_M) != '0);
        wmask   = {W{wr_en_i && qual_ok}} & bmask_i;
        lmask   = wmask & {W{unlock_i}};
        nxt     = (FREE_M & ((st_q.val & ~wmask) | (wdata_i & wmask)))
                | (RWL_M  & ((st_q.val & ~lmask) | (wdata_i & lmask)))
                | (ROS_M  & (st_q.val | hw_set_i))
                | (W1C_M  & ((st_q.val & ~(wmask & wdata_i)) | hw_set_i));
        keep    = aux_pwr ? SURV_M : '0;
        if (!fund_rst_n) begin
            st_d.val = (keep & st_q.val) | (~keep & DEF_M & LIVE_M);
        end else if (!hot_rst_n) begin
            st_d.val = ((STK_M | RWL_M) & st_q.val) | (RW_M & DEF_M);
        end else begin
            st_d.val = nxt;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign val_o = st_q.val;

    // R1
    lock_hold_chk: assert property (@(posedge clk) disable iff (!fund_rst_n)
        (!unlock_i) |=> ((val_o & RWL_M) == $past(val_o & RWL_M)));

    // R3
    ros_rise_chk: assert property (@(posedge clk) disable iff (!fund_rst_n)
        fund_rst_n |=> ((val_o & ROS_M & ~$past(val_o) & ~$past(hw_set_i)) == '0));

    // R3
    ros_nofall_chk: assert property (@(posedge clk) disable iff (!fund_rst_n)
        fund_rst_n |=> ((~val_o & $past(val_o & ROS_M)) == '0));

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!fund_rst_n)
        (hot_rst_n && ((hw_set_i & W1C_M) != '0))
        |=> ((val_o & $past(hw_set_i & W1C_M)) == $past(hw_set_i & W1C_M)));

    // R4
    hot_sticky_chk: assert property (@(posedge clk) disable iff (!fund_rst_n)
        (!hot_rst_n) |=> ((val_o & STK_M) == $past(val_o & STK_M)));

endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux #(
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned ADDR_W   = 3
) (
    input  logic                         clk,
    input  logic                         fund_rst_n,
    input  logic                         re_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [NUM_REGS*DATA_W-1:0]   regs_i,
    output logic [DATA_W-1:0]            rdata_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [DATA_W-1:0] pick;

    always_comb begin
        pick = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (addr_i == ADDR_W'(r)) begin
                pick = regs_i[r*DATA_W +: DATA_W];
            end
        end
        rd_d = rd_q;
        if (!fund_rst_n) begin
            rd_d.data = '0;
        end else if (re_i) begin
            rd_d.data = pick;
        end
    end

    always_ff @(posedge clk) begin
        rd_q <= rd_d;
    end

    assign rdata_o = rd_q.data;

    // R12
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!fund_rst_n)
        (re_i && (int'(addr_i) >= int'(NUM_REGS))) |=> (rdata_o == '0));

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!fund_rst_n)
        (!re_i) |=> $stable(rdata_o));

endmodule

// File: rtl/cfg_attr_regbank.sv
module cfg_attr_regbank #(
    parameter int unsigned NUM_REGS   = 4,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned ADDR_W     = 3,
    parameter int unsigned UNLOCK_REG = 0,
    parameter int unsigned UNLOCK_BIT = 0,
    parameter logic [NUM_REGS*DATA_W-1:0] RW_MASK  = 64'h7F00_0000_0000_00FF,
    parameter logic [NUM_REGS*DATA_W-1:0] RWL_MASK = 64'h0000_0000_FFFF_0000,
    parameter logic [NUM_REGS*DATA_W-1:0] ROS_MASK = 64'h0000_FF00_0000_0000,
    parameter logic [NUM_REGS*DATA_W-1:0] RWS_MASK = 64'h0000_00FF_0000_0000,
    parameter logic [NUM_REGS*DATA_W-1:0] W1C_MASK = 64'h00FF_0000_0000_0000,
    parameter logic [NUM_REGS*DATA_W-1:0] WT_MASK  = 64'h8000_0000_0000_0000,
    parameter logic [NUM_REGS*DATA_W-1:0] FRS_MASK = 64'h000F_0F0F_0000_0000,
    parameter logic [NUM_REGS*DATA_W-1:0] DEFAULTS = 64'h0000_A000_1234_0000
) (
    input  logic                         clk,
    input  logic                         fund_rst_n,
    input  logic                         hot_rst_n,
    input  logic                         aux_pwr,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [DATA_W/8-1:0]          wstrb,
    input  logic                         we,
    input  logic                         re,
    output logic [DATA_W-1:0]            rdata,
    input  logic [NUM_REGS*DATA_W-1:0]   hw_set
);
    localparam int unsigned UNLOCK_IDX = UNLOCK_REG * DATA_W + UNLOCK_BIT;

    logic [NUM_REGS-1:0]          wr_sel;
    logic [DATA_W-1:0]            bmask;
    logic [NUM_REGS*DATA_W-1:0]   reg_vals;
    logic                         unlock;

    cfg_wr_decode #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_dec (
        .addr_i   (addr),
        .we_i     (we),
        .wstrb_i  (wstrb),
        .wr_sel_o (wr_sel),
        .bmask_o  (bmask)
    );

    assign unlock = reg_vals[UNLOCK_IDX];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        cfg_reg_slice #(
            .W     (DATA_W),
            .RW_M  (RW_MASK [r*DATA_W +: DATA_W]),
            .RWL_M (RWL_MASK[r*DATA_W +: DATA_W]),
            .ROS_M (ROS_MASK[r*DATA_W +: DATA_W]),
            .RWS_M (RWS_MASK[r*DATA_W +: DATA_W]),
            .W1C_M (W1C_MASK[r*DATA_W +: DATA_W]),
            .WT_M  (WT_MASK [r*DATA_W +: DATA_W]),
            .FRS_M (FRS_MASK[r*DATA_W +: DATA_W]),
            .DEF_M (DEFAULTS[r*DATA_W +: DATA_W])
        ) u_slice (
            .clk        (clk),
            .fund_rst_n (fund_rst_n),
            .hot_rst_n  (hot_rst_n),
            .aux_pwr    (aux_pwr),
            .wr_en_i    (wr_sel[r]),
            .bmask_i    (bmask),
            .wdata_i    (wdata),
            .unlock_i   (unlock),
            .hw_set_i   (hw_set[r*DATA_W +: DATA_W]),
            .val_o      (reg_vals[r*DATA_W +: DATA_W])
        );
    end

    cfg_rd_mux #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_rd (
        .clk        (clk),
        .fund_rst_n (fund_rst_n),
        .re_i       (re),
        .addr_i     (addr),
        .regs_i     (reg_vals),
        .rdata_o    (rdata)
    );

    localparam logic [NUM_REGS*DATA_W-1:0] STORED =
        RW_MASK | RWL_MASK | ROS_MASK | RWS_MASK | W1C_MASK;

    // R9
    zero_bits_chk: assert property (@(posedge clk) disable iff (!fund_rst_n)
        fund_rst_n |=> ((reg_vals & ~STORED) == '0));

endmodule

// File: tb/cfg_attr_regbank_tb.sv
`timescale 1ns/1ps
module cfg_attr_regbank_tb;

    localparam int NR = 4;
    localparam int DW = 16;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          fund_rst_n = 1'b0;
    logic          hot_rst_n = 1'b1;
    logic          aux_pwr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [1:0]    wstrb = '0;
    logic          we = 1'b0;
    logic          re = 1'b0;
    logic [DW-1:0] rdata;
    logic [NR*DW-1:0] hw_set = '0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cfg_attr_regbank u_dut (
        .clk        (clk),
        .fund_rst_n (fund_rst_n),
        .hot_rst_n  (hot_rst_n),
        .aux_pwr    (aux_pwr),
        .addr       (addr),
        .wdata      (wdata),
        .wstrb      (wstrb),
        .we         (we),
        .re         (re),
        .rdata      (rdata),
        .hw_set     (hw_set)
    );

    // {is_write, addr[2:0], data[15:0], strobes[1:0], expected[15:0], req[3:0]}
    localparam int NV = 18;
    localparam logic [41:0] VEC [NV] = '{
        {1'b0, 3'd0, 16'h0000, 2'b00, 16'h0000, 4'd10}, // R10 reset value
        {1'b0, 3'd1, 16'h0000, 2'b00, 16'h1234, 4'd2},  // R2 default
        {1'b0, 3'd2, 16'h0000, 2'b00, 16'hA000, 4'd3},  // R3 default
        {1'b0, 3'd3, 16'h0000, 2'b00, 16'h0000, 4'd5},  // R5 default
        {1'b1, 3'd1, 16'h5555, 2'b11, 16'h0000, 4'd1},
        {1'b0, 3'd1, 16'h0000, 2'b00, 16'h1234, 4'd1},  // R1 locked write dropped
        {1'b1, 3'd0, 16'hFFFF, 2'b11, 16'h0000, 4'd9},
        {1'b0, 3'd0, 16'h0000, 2'b00, 16'h00FF, 4'd9},  // R9 zero byte ignored
        {1'b1, 3'd1, 16'hABCD, 2'b01, 16'h0000, 4'd11},
        {1'b0, 3'd1, 16'h0000, 2'b00, 16'h12CD, 4'd11}, // R11 low lane only
        {1'b1, 3'd1, 16'hABCD, 2'b10, 16'h0000, 4'd11},
        {1'b0, 3'd1, 16'h0000, 2'b00, 16'hABCD, 4'd1},  // R1 unlocked write lands
        {1'b1, 3'd2, 16'hFFFF, 2'b11, 16'h0000, 4'd4},
        {1'b0, 3'd2, 16'h0000, 2'b00, 16'hA0FF, 4'd4},  // R4 R3 sticky rw vs ro
        {1'b1, 3'd3, 16'h7FFF, 2'b11, 16'h0000, 4'd8},
        {1'b0, 3'd3, 16'h0000, 2'b00, 16'h0000, 4'd8},  // R8 no qualifier
        {1'b1, 3'd3, 16'hFF00, 2'b11, 16'h0000, 4'd8},
        {1'b0, 3'd3, 16'h0000, 2'b00, 16'h7F00, 4'd8}   // R8 qualified, reads 0
    };

    task automatic check(input int req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d, input logic [1:0] s);
        @(negedge clk);
        addr = AW'(a); wdata = d; wstrb = s; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wstrb = '0;
    endtask

    task automatic rd(input int a, input int req, input logic [DW-1:0] exp);
        @(negedge clk);
        addr = AW'(a); re = 1'b1;
        @(negedge clk);
        re = 1'b0;
        check(req, rdata, exp);
    endtask

    task automatic pulse_hw(input logic [NR*DW-1:0] v);
        @(negedge clk);
        hw_set = v;
        @(negedge clk);
        hw_set = '0;
    endtask

    task automatic do_fund(input logic aux);
        @(negedge clk);
        aux_pwr = aux; fund_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        fund_rst_n = 1'b1;
    endtask

    task automatic do_hot();
        @(negedge clk);
        hot_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        hot_rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        fund_rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][41]) wr(int'(VEC[i][40:38]), VEC[i][37:22], VEC[i][21:20]);
            else            rd(int'(VEC[i][40:38]), int'(VEC[i][3:0]), VEC[i][19:4]);
        end

        // R5 R3 hardware events
        pulse_hw(64'h000F_0100_0000_0000);
        rd(3, 5, 16'h7F0F);
        rd(2, 3, 16'hA1FF);
        // R5 write-1 clears bit 0
        wr(3, 16'h8001, 2'b11);
        rd(3, 5, 16'h000E);
        // R8 clear without qualifier is blocked
        wr(3, 16'h0002, 2'b11);
        rd(3, 8, 16'h000E);
        // R6 set and clear of bit 2 together
        @(negedge clk);
        addr = 3'd3; wdata = 16'h8004; wstrb = 2'b11; we = 1'b1;
        hw_set = 64'h0004_0000_0000_0000;
        @(negedge clk);
        we = 1'b0; hw_set = '0;
        rd(3, 6, 16'h000E);
        // R5 write of 0 leaves status
        wr(3, 16'h8A00, 2'b11);
        rd(3, 5, 16'h0A0E);
        wr(2, 16'h0055, 2'b01);
        rd(2, 4, 16'hA155);

        // hot reset
        do_hot();
        rd(0, 10, 16'h0000); // R10
        rd(1, 2, 16'hABCD);  // R2
        rd(2, 4, 16'hA155);  // R4 R3
        rd(3, 5, 16'h000E);  // R5 status kept, rw bits default
        wr(1, 16'h0000, 2'b11);
        rd(1, 1, 16'hABCD);  // R1 relocked by hot reset

        // R7 fundamental with aux
        do_fund(1'b1);
        rd(1, 2, 16'h1234);  // R2
        rd(2, 7, 16'hA105);  // R7
        rd(3, 7, 16'h000E);  // R7
        rd(0, 7, 16'h0000);
        // R7 fundamental without aux
        do_fund(1'b0);
        rd(2, 7, 16'hA000);
        rd(3, 7, 16'h0000);

        // R12 hold and unmapped
        rd(1, 12, 16'h1234);
        @(negedge clk);
        addr = 3'd2;
        @(negedge clk);
        check(12, rdata, 16'h1234);
        rd(5, 12, 16'h0000);
        rd(1, 12, 16'h1234);
        rd(7, 12, 16'h0000);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule